// File: doc/BRIEF.md
# Streaming Sobel Edge Filter

This block turns a raster-ordered stream of 8-bit grayscale pixels, one frame of 128 columns by 128 lines, into a stream of signed edge strengths with one result per accepted pixel. Two line stores keep the two preceding lines. A three-column window of registers slides along the current line. Both gradient kernels are evaluated from this window in parallel in the same clock cycle. Of the two signed gradient sums, the larger one is passed on. No absolute value, root or angle is formed.

The input is a valid/pixel pair with a start-of-frame flag. A pixel is taken on every cycle where the valid input is high, so the source may leave gaps of any length. While the valid input is low, nothing inside the filter moves. When the pixel at line r, column c arrives, the window is complete for the pixel at (r-1, c-1), and that result leaves the block on the next clock. The output stream is therefore the frame in raster order, delayed by one line plus one pixel (129 accepted beats). Every pixel on the outer ring of the frame produces the value 0. The last 129 results of a frame are all on that ring, and they come out during the first 129 beats of the following frame.

A small sequencer steps through three states. WAIT_SOF is entered on reset and ignores all input until a beat with the start-of-frame flag arrives, which moves it to FILL. FILL counts beats of the first frame without producing output and moves to STREAM on the first beat that completes a window, at position (1,1). STREAM produces one output for every accepted beat and is left only by reset.

Top module: `sobel_edge_stream`

## Requirements
- R1: After reset, input beats are ignored until one arrives with `in_sof` high. Ignored beats produce no output and do not move the position counters.
- R2: A beat with `in_sof` high is position (line 0, column 0). Each later beat advances the column, and then the line, in raster order. After (127,127) the count wraps to (0,0) even if `in_sof` is low.
- R3: In WAIT_SOF no output is produced. In STREAM, every accepted beat produces exactly one output, with `out_valid` high for one cycle on the clock after the beat. A cycle without an accepted beat produces none.
- R4: In the first frame after reset, the beats at positions (0,0) through (1,0) produce no output. Output starts at the beat at (1,1), where the state moves from FILL to STREAM.
- R5: `out_sof` is high only together with `out_valid`. It marks the result for pixel (0,0), which is emitted on the clock after the beat at position (1,1).
- R6: The result for any pixel in line 0, line 127, column 0 or column 127 is 0.
- R7: Gx, for an interior pixel, is the sum of the right window column minus the sum of the left window column. In each sum the middle line is weighted 2 and the upper and lower lines are weighted 1. The right column is the newest column.
- R8: Gy, for an interior pixel, is the sum of the bottom window line minus the sum of the top window line. In each sum the middle column is weighted 2. The bottom line is the newest line.
- R9: `out_edge` is the larger of Gx and Gy as signed values, in 11-bit two's complement, always within -1020 to +1020.
- R10: A synchronous active-high `rst` clears `out_valid`, `out_sof` and `out_edge`, the counters and the window, and returns to WAIT_SOF.
- R11: Idle cycles between beats do not change any result. A frame sent with gaps gives the same output values as the same frame sent without them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Pixel beat present |
| in_sof | input | 1 | This beat is frame position (0,0) |
| in_pix | input | 8 | Unsigned grayscale sample |
| out_valid | output | 1 | Result present, one clock after its completing beat |
| out_sof | output | 1 | Result belongs to pixel (0,0) |
| out_edge | output | 11 | Signed maximum of the two gradients, 0 on the border |

## Verification
The bench goes after the pixels next to the frame ring, where a filter that is off by one line or one column would put a non-zero value in column 127 or line 0, or leave an interior pixel at zero. It also tests a vertical step whose gradient reaches +1020 and a diagonal ramp where both gradients are negative. A design that clipped the step, swapped the kernel orientation or compared the values as unsigned would give the wrong magnitude or sign there. Other stimulus covers junk beats before the first start flag, a frame that relies on the counter wrap, dense idle gaps and a reset in the middle of a frame. These catch a design that leaks output before alignment, drifts the window during stalls, or emits stale results after reset.

// File: rtl/sobel_pkg.sv
package sobel_pkg;

    // Sequencer states of the raster scan controller
    typedef enum logic [1:0] {
        ST_WAIT_SOF = 2'd0,
        ST_FILL     = 2'd1,
        ST_STREAM   = 2'd2
    } scan_state_t;

    // Extra bits a gradient needs over a pixel: weight sum 4 plus sign
    localparam int GRAD_EXTRA = 3;

endpackage

// File: rtl/sobel_scan_ctrl.sv
module sobel_scan_ctrl
    import sobel_pkg::*;
#(
    parameter int IMG_W = 128,
    parameter int IMG_H = 128,
    localparam int CW = $clog2(IMG_W),
    localparam int RW = $clog2(IMG_H)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_sof,
    output logic          beat,
    output logic [CW-1:0] col,
    output logic          emit,
    output logic          interior,
    output logic          centre_origin
);

    scan_state_t   state_q, state_d;
    logic [RW-1:0] row_q;
    logic [CW-1:0] col_q;
    logic [RW-1:0] row;
    logic          past_fill;

    // Position of the current beat; a start flag forces the origin
    always_comb begin
        row = in_sof ? '0 : row_q;
        col = in_sof ? '0 : col_q;
        past_fill = (row > RW'(1)) || ((row == RW'(1)) && (col != '0));
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_WAIT_SOF;
        else     state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_SOF: if (in_valid && in_sof) state_d = ST_FILL;
            ST_FILL:     if (beat && past_fill)  state_d = ST_STREAM;
            ST_STREAM:   state_d = ST_STREAM;
            default:     state_d = ST_WAIT_SOF;
        endcase
    end

    // Outputs of the sequencer
    always_comb begin
        beat          = in_valid && ((state_q != ST_WAIT_SOF) || in_sof);
        emit          = beat && ((state_q == ST_STREAM) ||
                                 ((state_q == ST_FILL) && past_fill));
        interior      = (row >= RW'(2)) && (col >= CW'(2));
        centre_origin = (row == RW'(1)) && (col == CW'(1));
    end

    // Raster counters, advanced on accepted beats only
    always_ff @(posedge clk) begin
        if (rst) begin
            row_q <= '0;
            col_q <= '0;
        end else if (beat) begin
            if (col == CW'(IMG_W - 1)) begin
                col_q <= '0;
                row_q <= (row == RW'(IMG_H - 1)) ? '0 : row + RW'(1);
            end else begin
                col_q <= col + CW'(1);
                row_q <= row;
            end
        end
    end

endmodule

// File: rtl/sobel_line_store.sv
module sobel_line_store #(
    parameter int DEPTH = 128,
    parameter int PIX_W = 8,
    parameter int LINES = 2,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        adv,
    input  logic [AW-1:0]               addr,
    input  logic [PIX_W-1:0]            din,
    output logic [LINES-1:0][PIX_W-1:0] taps
);

    // chain[0] is the live pixel, chain[k] the same column k lines back
    logic [LINES:0][PIX_W-1:0] chain;
    assign chain[0] = din;

    for (genvar k = 0; k < LINES; k++) begin : g_line
        logic [PIX_W-1:0] mem [DEPTH];

        assign chain[k+1] = mem[addr];
        assign taps[k]    = chain[k+1];

        // Read-before-write: the old entry is used this beat, replaced after
        always_ff @(posedge clk) begin
            if (adv) mem[addr] <= chain[k];
        end
    end

endmodule

// File: rtl/sobel_grad_core.sv
module sobel_grad_core
    import sobel_pkg::*;
#(
    parameter int PIX_W = 8,
    localparam int GRAD_W = PIX_W + GRAD_EXTRA
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     adv,
    input  logic [2:0][PIX_W-1:0]    col_new,   // [0] oldest line, [2] live pixel
    output logic signed [GRAD_W-1:0] edge_max
);

    logic [2:0][PIX_W-1:0]    col_l, col_m;
    logic signed [GRAD_W-1:0] gx, gy;

    // Two held columns; the third is the incoming one
    always_ff @(posedge clk) begin
        if (rst) begin
            col_l <= '0;
            col_m <= '0;
        end else if (adv) begin
            col_l <= col_m;
            col_m <= col_new;
        end
    end

    function automatic logic signed [GRAD_W-1:0] widen(input logic [PIX_W-1:0] p);
        return $signed({{(GRAD_W - PIX_W){1'b0}}, p});
    endfunction

    always_comb begin
        gx = (widen(col_new[0]) + (widen(col_new[1]) <<< 1) + widen(col_new[2]))
           - (widen(col_l[0])   + (widen(col_l[1])   <<< 1) + widen(col_l[2]));
        gy = (widen(col_l[2])   + (widen(col_m[2])   <<< 1) + widen(col_new[2]))
           - (widen(col_l[0])   + (widen(col_m[0])   <<< 1) + widen(col_new[0]));
        edge_max = (gx > gy) ? gx : gy;
    end

endmodule

// File: rtl/sobel_edge_stream.sv
module sobel_edge_stream
    import sobel_pkg::*;
#(
    parameter int IMG_W = 128,
    parameter int IMG_H = 128,
    parameter int PIX_W = 8,
    localparam int GRAD_W = PIX_W + GRAD_EXTRA,
    localparam int CW = $clog2(IMG_W)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic                     in_sof,
    input  logic [PIX_W-1:0]         in_pix,
    output logic                     out_valid,
    output logic                     out_sof,
    output logic signed [GRAD_W-1:0] out_edge
);

    logic                      beat, emit, interior, centre_origin;
    logic [CW-1:0]             col;
    logic [1:0][PIX_W-1:0]     taps;
    logic signed [GRAD_W-1:0]  edge_max;

    sobel_scan_ctrl #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .in_sof        (in_sof),
        .beat          (beat),
        .col           (col),
        .emit          (emit),
        .interior      (interior),
        .centre_origin (centre_origin)
    );

    sobel_line_store #(.DEPTH(IMG_W), .PIX_W(PIX_W), .LINES(2)) u_lines (
        .clk  (clk),
        .adv  (beat),
        .addr (col),
        .din  (in_pix),
        .taps (taps)
    );

    sobel_grad_core #(.PIX_W(PIX_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .adv      (beat),
        .col_new  ({in_pix, taps[0], taps[1]}),
        .edge_max (edge_max)
    );

    // Single output register stage
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_edge  <= '0;
        end else begin
            out_valid <= emit;
            out_sof   <= emit && centre_origin;
            if (emit) out_edge <= interior ? edge_max : '0;
        end
    end

endmodule

// File: rtl/sobel_edge_stream_chk.sv
module sobel_edge_stream_chk #(
    parameter int IMG_W = 128,
    parameter int IMG_H = 128,
    parameter int GRAD_W = 11,
    localparam int NPIX = IMG_W * IMG_H,
    localparam int PW = $clog2(NPIX)
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic                     in_sof,
    input logic                     out_valid,
    input logic                     out_sof,
    input logic signed [GRAD_W-1:0] out_edge
);

    logic          in_seen_q, out_seen_q;
    logic [PW-1:0] opos_q, nxt, cur;
    int            cur_row, cur_col;
    logic          on_ring;

    always_comb begin
        nxt     = (opos_q == PW'(NPIX - 1)) ? '0 : opos_q + PW'(1);
        cur     = out_sof ? '0 : nxt;
        cur_row = int'(cur) / IMG_W;
        cur_col = int'(cur) % IMG_W;
        on_ring = (cur_row == 0) || (cur_row == IMG_H - 1) ||
                  (cur_col == 0) || (cur_col == IMG_W - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_seen_q  <= 1'b0;
            out_seen_q <= 1'b0;
            opos_q     <= '0;
        end else begin
            if (in_valid && in_sof) in_seen_q <= 1'b1;
            if (out_valid) begin
                if (out_sof) out_seen_q <= 1'b1;
                opos_q <= cur;
            end
        end
    end

    // R1: nothing leaves before a start flag was taken
    a_r1_silent_before_sof: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> in_seen_q);

    // R3: every result follows an input beat
    a_r3_result_needs_beat: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R5: start marker only on a valid result
    a_r5_sof_with_valid: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> out_valid);

    // R5: frame markers come exactly one frame of results apart
    a_r5_sof_at_wrap: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_seen_q) |-> (out_sof == (nxt == '0)));

    // R6: ring pixels give zero
    a_r6_ring_zero: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (out_seen_q || out_sof) && on_ring) |-> (out_edge == '0));

    // R9: result stays inside the reachable gradient range
    a_r9_in_range: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_edge <= 1020) && (out_edge >= -1020)));

    // R10: no result on the first cycle out of reset
    a_r10_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && !out_sof && (out_edge == '0)));

endmodule

bind sobel_edge_stream sobel_edge_stream_chk #(
    .IMG_W (IMG_W),
    .IMG_H (IMG_H),
    .GRAD_W(GRAD_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_sof   (in_sof),
    .out_valid(out_valid),
    .out_sof  (out_sof),
    .out_edge (out_edge)
);

// File: tb/sobel_edge_stream_test.sv
module sobel_edge_stream_test;

    localparam int CLK_PERIOD = 10;
    localparam int W = 128;
    localparam int H = 128;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_sof = 1'b0;
    logic [7:0]        in_pix = 8'h00;
    logic              out_valid;
    logic              out_sof;
    logic signed [10:0] out_edge;

    sobel_edge_stream uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_pix(in_pix),
        .out_valid(out_valid), .out_sof(out_sof), .out_edge(out_edge)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;
    // Expectation for the beat driven in the previous cycle
    bit    pend_v = 0;
    bit    pend_s = 0;
    int    pend_e = 0;
    string pend_vtag = "R10";
    string pend_etag = "R10";

    // Test images, generated from coordinates
    function automatic int pat(int k, int r, int c);
        case (k)
            0: return 100;
            1: return 2 * c;
            2: return 2 * r;
            3: return (c < 64) ? 0 : 255;
            4: return 255 - r - c;
            default: return (r * 37 + c * 91 + r * c * 13 + 11) % 256;
        endcase
    endfunction

    // Behavioural Sobel of pixel (r,c): larger signed gradient
    function automatic int sob(int k, int r, int c);
        int gx = 0;
        int gy = 0;
        for (int dr = -1; dr <= 1; dr++) begin
            for (int dc = -1; dc <= 1; dc++) begin
                int p = pat(k, r + dr, c + dc);
                gx += p * dc * ((dr == 0) ? 2 : 1);
                gy += p * dr * ((dc == 0) ? 2 : 1);
            end
        end
        return (gx > gy) ? gx : gy;
    endfunction

    // One clock: check last cycle's result, then drive this cycle
    task automatic step(input bit rs, input bit v, input bit s, input int pix,
                        input bit ev, input bit es, input int ee,
                        input string vtag, input string etag);
        @(negedge clk);
        n_cmp++;
        if (out_valid !== pend_v) begin
            n_bad++;
            $display("FAIL %s out_valid actual %0b expected %0b", pend_vtag, out_valid, pend_v);
        end else if (out_sof !== pend_s) begin
            n_bad++;
            $display("FAIL R5 out_sof actual %0b expected %0b", out_sof, pend_s);
        end else if (pend_v && ($signed(out_edge) != pend_e)) begin
            n_bad++;
            $display("FAIL %s out_edge actual %0d expected %0d", pend_etag, $signed(out_edge), pend_e);
        end else if (!pend_v && (pend_vtag == "R10") && (out_edge !== 11'sd0)) begin
            n_bad++;
            $display("FAIL R10 out_edge after reset actual %0d expected 0", $signed(out_edge));
        end
        rst = rs;
        in_valid = v;
        in_sof = s;
        in_pix = pix[7:0];
        pend_v = ev;
        pend_s = es;
        pend_e = ee;
        pend_vtag = vtag;
        pend_etag = etag;
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 8'h5A, 0, 0, 0, tag, tag);
    endtask

    task automatic do_reset();
        // R10: outputs cleared while and right after reset is held
        repeat (3) step(1, 0, 0, 0, 0, 0, 0, "R10", "R10");
        idle("R10");
    endtask

    // Send lines 0..nrows-1 of image k
    task automatic send_frame(input int k, input bit with_sof, input bit gaps,
                              input bit first, input int nrows, input string tag);
        for (int r = 0; r < nrows; r++) begin
            for (int c = 0; c < W; c++) begin
                int  idx = r * W + c;
                bit  ev = !(first && (idx < W + 1));
                bit  inner = (r >= 2) && (c >= 2);
                int  ee = inner ? sob(k, r - 1, c - 1) : 0;
                string vt = (first && (idx < W + 1)) ? "R4" : "R3";
                string et = inner ? tag : "R6";
                // R11: idle cycles sprinkled between beats
                if (gaps && ((r * 7 + c * 3) % 5 == 0)) begin
                    idle("R11");
                    if ((c % 3) == 0) idle("R11");
                end
                step(0, 1, with_sof && (idx == 0), pat(k, r, c),
                     ev, ev && (r == 1) && (c == 1), ee, vt, et);
            end
        end
    endtask

    initial begin
        do_reset();
        // R1: beats without a start flag are ignored
        for (int i = 0; i < 6; i++) step(0, 1, 0, 8'hC3 + i, 0, 0, 0, "R1", "R1");
        idle("R1");
        // R7: horizontal ramp, R4 fill on this first frame
        send_frame(1, 1, 0, 1, H, "R7");
        // R8: vertical ramp
        send_frame(2, 1, 0, 0, H, "R8");
        // R7 / R9: step edge reaching +1020
        send_frame(3, 1, 0, 0, H, "R9");
        // R9: both gradients negative
        send_frame(4, 1, 0, 0, H, "R9");
        // R11: textured image with idle gaps
        send_frame(5, 1, 1, 0, H, "R11");
        // R2: flat frame relying on counter wrap, no start flag
        send_frame(0, 0, 0, 0, H, "R2");
        // R10: reset in the middle of a frame, then a fresh first frame
        send_frame(5, 1, 0, 0, 40, "R9");
        do_reset();
        send_frame(5, 1, 0, 1, H, "R9");
        repeat (4) idle("R3");
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog run did not complete, actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule